// File: doc/BRIEF.md
# Variable-Length Block Boundary Synchronizer

This block takes the 32-bit parallel words that a deserializer delivers at an unknown bit offset and finds the boundaries of 130-bit line-code blocks in them. Each block starts with a 2-bit sync header. After the header comes a payload of 32-bit words. A normal block has four payload words. A skip ordered set has between two and six payload words, so it is 66 to 194 bits long.

While unaligned, the block tests all 32 bit offsets at once. At each offset it looks for an ordered-set header followed by the opening word of an electrical-idle-exit set or of a skip set. The lowest offset that matches becomes the block boundary. From that point on, the block reads the sync header of every block and emits the payload as aligned words. It measures the length of each skip set and starts the next block directly after that set's last word, so the boundary is set again after every skip set.

Each block consumes 130 bits, but only 128 bits arrive in four cycles. As a result, the output drops valid for one cycle about every sixteen blocks. Lock is lost after a run of invalid sync headers, and the search then starts again.

The state machine has five states:

- `ST_FILL`: the two-word history is loading after reset. It moves to `ST_SEARCH` once both words are in.
- `ST_SEARCH`: the offset scan is running. On a match it emits the matched block's first word and moves to `ST_BODY` for an electrical-idle-exit set or to `ST_SKP` for a skip set.
- `ST_HEAD`: the next bits are a sync header plus payload word 0.
  - It stalls when the buffered bits are too few for 34 bits.
  - It returns to `ST_SEARCH` on the final invalid header of a run.
  - Otherwise it moves to `ST_SKP` for a skip set or to `ST_BODY` for any other block.
- `ST_BODY`: emits payload words 1 to 3, then returns to `ST_HEAD`.
- `ST_SKP`: emits skip-set words until it sees the end-marker word or reaches the length cap, then returns to `ST_HEAD`.

Top module: `blksync_core`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, `locked` and `out_valid` are 0.
- R2: The stream is read least significant bit first, with word n before word n+1. The header field is {second bit, first bit}. Payload byte k occupies the 8 bits after the header starting at bit 8k, least significant bit first. `out_data` byte i holds payload byte 4m+i of payload word m.
- R3: Header 01 followed by payload bytes 00h, FFh, 00h, FFh at any bit offset 0 to 31 causes lock. That block is emitted as four words, with `out_start` high on the first word.
- R4: Header 01 followed by four AAh bytes at any offset causes lock, and the block is treated as a skip set.
- R5: Every block begins with one word that has `out_start` high and `out_hdr` equal to its header. That word is followed by the block's remaining payload words. A block whose header is not a skip-set opening has exactly four words.
- R6: A skip set has 1 to 5 words of AAh bytes, then one word whose byte 0 is E1h. The next block header follows that word immediately, for every length from 66 to 194 bits.
- R7: No word is lost, repeated or reordered. `out_valid` drops only where the input has not yet supplied enough bits.
- R8: Four consecutive headers of 00 or 11 clear `locked`, and the fourth of those blocks is not emitted. A valid header in between resets the count.
- R9: `out_valid` high implies `locked` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_word | input | 32 | Deserialized word, one per cycle, arbitrary bit alignment |
| out_valid | output | 1 | out_data holds an aligned payload word |
| out_start | output | 1 | This word is the first of a block |
| out_hdr | output | 2 | Sync header of the block, valid with out_start |
| out_data | output | 32 | Aligned payload word |
| locked | output | 1 | Block alignment held |

## Verification
The bench uses the default parameters: a four-header loss limit and a six-word skip cap. It sweeps all 32 starting bit offsets. Sweeps alternate between acquiring lock on an electrical-idle-exit set and acquiring it on a skip set. Every sweep contains skip sets of all five lengths and enough normal blocks to cross the stall point of the 130/128 ratio. Each sweep ends with a broken and then a complete run of invalid headers. Together, these cover every pointer position the realignment logic can reach.

// File: rtl/blksync_pkg.sv
package blksync_pkg;
    localparam int WORD_W = 32;
    localparam int WIN_W  = 3 * WORD_W;
    localparam int SEG_W  = WORD_W + 2;
    localparam int OFF_W  = $clog2(WORD_W);
    localparam int PTR_W  = $clog2(WIN_W) + 1;

    localparam logic [1:0]        HDR_OS   = 2'b01;
    localparam logic [WORD_W-1:0] EIE_WORD = 32'hFF00FF00;
    localparam logic [WORD_W-1:0] SKP_FILL = 32'hAAAAAAAA;
    localparam logic [7:0]        SKP_END  = 8'hE1;

    typedef enum logic [2:0] {
        ST_FILL,
        ST_SEARCH,
        ST_HEAD,
        ST_BODY,
        ST_SKP
    } bs_state_t;
endpackage

// File: rtl/blksync_finder.sv
module blksync_finder
    import blksync_pkg::*;
(
    input  logic [WIN_W-1:0] win,
    output logic             hit,
    output logic [OFF_W-1:0] hit_off
);
    logic [WORD_W-1:0] match;

    generate
        for (genvar o = 0; o < WORD_W; o++) begin : g_off
            logic [SEG_W-1:0] cand;
            assign cand     = win[o +: SEG_W];
            assign match[o] = (cand[1:0] == HDR_OS) &&
                              ((cand[SEG_W-1:2] == EIE_WORD) ||
                               (cand[SEG_W-1:2] == SKP_FILL));
        end
    endgenerate

    always_comb begin
        hit     = |match;
        hit_off = '0;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            if (match[i]) hit_off = OFF_W'(i);
        end
    end
endmodule

// File: rtl/blksync_slice.sv
module blksync_slice
    import blksync_pkg::*;
(
    input  logic [WIN_W-1:0] win,
    input  logic [PTR_W-1:0] ptr,
    output logic [SEG_W-1:0] seg
);
    logic [WIN_W-1:0] shifted;
    assign shifted = win >> ptr;
    assign seg     = shifted[SEG_W-1:0];
endmodule

// File: rtl/blksync_core.sv
module blksync_core
    import blksync_pkg::*;
#(
    parameter int BAD_LIMIT = 4,
    parameter int SKP_MAX   = 6
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] in_word,
    output logic        out_valid,
    output logic        out_start,
    output logic [1:0]  out_hdr,
    output logic [31:0] out_data,
    output logic        locked
);
    localparam int BAD_W = $clog2(BAD_LIMIT) + 1;
    localparam int CNT_W = $clog2(SKP_MAX) + 1;
    localparam logic [PTR_W-1:0] HEAD_TAKE = PTR_W'(SEG_W);
    localparam logic [PTR_W-1:0] WIN_BITS  = PTR_W'(WIN_W);
    localparam logic [PTR_W-1:0] WORD_BITS = PTR_W'(WORD_W);

    bs_state_t         state, nxt;
    logic [WORD_W-1:0] d1, d2;
    logic [1:0]        fill;
    logic [PTR_W-1:0]  ptr, ptr_n, sel_ptr;
    logic [CNT_W-1:0]  cnt, cnt_n;
    logic [BAD_W-1:0]  bad, bad_n;
    logic [WIN_W-1:0]  win;
    logic [SEG_W-1:0]  seg;
    logic              hit;
    logic [OFF_W-1:0]  hit_off;
    logic              o_v, o_s;
    logic [1:0]        o_h;
    logic [WORD_W-1:0] o_d;
    logic              hdr_bad, is_skp;

    assign win = {in_word, d1, d2};

    blksync_finder u_find (.win(win), .hit(hit), .hit_off(hit_off));

    assign sel_ptr = (state == ST_SEARCH) ? PTR_W'(hit_off) : ptr;

    blksync_slice u_slice (.win(win), .ptr(sel_ptr), .seg(seg));

    assign hdr_bad = (seg[1:0] == 2'b00) || (seg[1:0] == 2'b11);
    assign is_skp  = (seg[1:0] == HDR_OS) && (seg[SEG_W-1:2] == SKP_FILL);

    always_comb begin
        nxt   = state;
        ptr_n = ptr;
        cnt_n = cnt;
        bad_n = bad;
        o_v   = 1'b0;
        o_s   = 1'b0;
        o_h   = seg[1:0];
        o_d   = seg[WORD_W-1:0];
        unique case (state)
            ST_FILL: begin
                if (fill == 2'd2) nxt = ST_SEARCH;
            end
            ST_SEARCH: begin
                if (hit) begin
                    o_v   = 1'b1;
                    o_s   = 1'b1;
                    o_d   = seg[SEG_W-1:2];
                    ptr_n = PTR_W'(hit_off) + 2'd2;
                    cnt_n = CNT_W'(1);
                    bad_n = '0;
                    nxt   = is_skp ? ST_SKP : ST_BODY;
                end
            end
            ST_HEAD: begin
                if (ptr + HEAD_TAKE > WIN_BITS) begin
                    ptr_n = ptr - WORD_BITS;
                end else if (hdr_bad && (bad == BAD_W'(BAD_LIMIT - 1))) begin
                    bad_n = '0;
                    nxt   = ST_SEARCH;
                end else begin
                    o_v   = 1'b1;
                    o_s   = 1'b1;
                    o_d   = seg[SEG_W-1:2];
                    ptr_n = ptr + 2'd2;
                    cnt_n = CNT_W'(1);
                    bad_n = hdr_bad ? bad + 1'b1 : '0;
                    nxt   = is_skp ? ST_SKP : ST_BODY;
                end
            end
            ST_BODY: begin
                o_v   = 1'b1;
                cnt_n = cnt + 1'b1;
                if (cnt == CNT_W'(3)) nxt = ST_HEAD;
            end
            ST_SKP: begin
                o_v   = 1'b1;
                cnt_n = cnt + 1'b1;
                if ((seg[7:0] == SKP_END) || (cnt == CNT_W'(SKP_MAX - 1)))
                    nxt = ST_HEAD;
            end
            default: nxt = ST_FILL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_FILL;
            d1    <= '0;
            d2    <= '0;
            fill  <= '0;
            ptr   <= '0;
            cnt   <= '0;
            bad   <= '0;
        end else begin
            state <= nxt;
            d1    <= in_word;
            d2    <= d1;
            if (fill != 2'd2) fill <= fill + 1'b1;
            ptr   <= ptr_n;
            cnt   <= cnt_n;
            bad   <= bad_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_start <= 1'b0;
            out_hdr   <= '0;
            out_data  <= '0;
            locked    <= 1'b0;
        end else begin
            out_valid <= o_v;
            out_start <= o_s;
            out_hdr   <= o_h;
            out_data  <= o_d;
            locked    <= (nxt != ST_SEARCH) && (nxt != ST_FILL);
        end
    end
endmodule

// File: rtl/blksync_checker.sv
module blksync_checker #(
    parameter int SKP_MAX = 6
) (
    input logic       clk,
    input logic       rst,
    input logic       out_valid,
    input logic       out_start,
    input logic [1:0] out_hdr,
    input logic       locked
);
    logic [7:0] run;

    always_ff @(posedge clk) begin
        if (rst) run <= '0;
        else if (out_valid) run <= out_start ? 8'd1 : run + 8'd1;
    end

    assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!locked && !out_valid));

    assert_start_is_valid_R5: assert property (@(posedge clk) disable iff (rst)
        out_start |-> out_valid);

    assert_lock_begins_block_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> (out_start && out_hdr == 2'b01));

    assert_block_len_cap_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_start) |-> (run < 8'(SKP_MAX)));

    assert_valid_needs_lock_R9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> locked);
endmodule

bind blksync_core blksync_checker #(.SKP_MAX(SKP_MAX)) u_chk (
    .clk(clk), .rst(rst), .out_valid(out_valid), .out_start(out_start),
    .out_hdr(out_hdr), .locked(locked)
);

// File: tb/blksync_core_test.sv
module blksync_core_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] in_word;
    logic        out_valid, out_start, locked;
    logic [1:0]  out_hdr;
    logic [31:0] out_data;

    always #4 clk = ~clk;

    blksync_core uut (
        .clk(clk), .rst(rst), .in_word(in_word), .out_valid(out_valid),
        .out_start(out_start), .out_hdr(out_hdr), .out_data(out_data),
        .locked(locked)
    );

    bit          sq[$];
    logic [31:0] ed[$];
    logic [1:0]  eh[$];
    bit          es[$];
    bit          expect_out;
    bit          running;
    int          checks = 0;
    int          fails  = 0;
    int          blkno;

    task automatic chk(bit ok, string req, string msg);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s", req, msg);
        end
    endtask

    task automatic add_hdr(logic [1:0] h);
        sq.push_back(h[0]);
        sq.push_back(h[1]);
    endtask

    task automatic add_word(logic [31:0] w, bit first, logic [1:0] h);
        for (int i = 0; i < 32; i++) sq.push_back(w[i]);
        if (expect_out) begin
            ed.push_back(w);
            es.push_back(first);
            eh.push_back(h);
        end
    endtask

    task automatic data_blk(logic [1:0] h);
        add_hdr(h);
        for (int j = 0; j < 4; j++)
            add_word({8'(blkno), 8'(j), 16'hC3A5}, j == 0, h);
        blkno++;
    endtask

    task automatic eie_blk();
        add_hdr(2'b01);
        for (int j = 0; j < 4; j++) add_word(32'hFF00FF00, j == 0, 2'b01);
        blkno++;
    endtask

    // R6: k AAh words then one word with byte 0 = E1h
    task automatic skp_blk(int k);
        add_hdr(2'b01);
        for (int j = 0; j < k; j++) add_word(32'hAAAAAAAA, j == 0, 2'b01);
        add_word({8'h56, 8'(k), 8'h34, 8'hE1}, 1'b0, 2'b01);
        blkno++;
    endtask

    // sampled away from the edge
    always @(negedge clk) begin
        if (running && out_valid) begin
            if (ed.size() == 0) begin
                chk(1'b0, "R7", $sformatf("unexpected word act=%h exp=none", out_data));
            end else begin
                logic [31:0] xd;
                logic [1:0]  xh;
                bit          xs;
                xd = ed.pop_front();
                xh = eh.pop_front();
                xs = es.pop_front();
                chk(out_data == xd, "R2/R7",
                    $sformatf("data act=%h exp=%h", out_data, xd));
                chk(out_start == xs, "R5",
                    $sformatf("start act=%0d exp=%0d", out_start, xs));
                if (xs)
                    chk(out_hdr == xh, "R5",
                        $sformatf("hdr act=%b exp=%b", out_hdr, xh));
            end
            chk(locked, "R9", $sformatf("locked act=%0d exp=1", locked));
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst     = 1'b1;
        in_word = '0;
        running = 1'b0;
        for (int off = 0; off < 32; off++) begin
            rst     = 1'b1;
            running = 1'b0;
            in_word = '0;
            sq.delete(); ed.delete(); eh.delete(); es.delete();
            blkno      = 0;
            expect_out = 1'b1;
            // R3/R4: leading zeros put the boundary at offset off
            for (int i = 0; i < 64 + off; i++) sq.push_back(1'b0);
            if (off % 2 == 0) eie_blk();      // R3
            else skp_blk((off / 2) % 5 + 1); // R4
            for (int i = 0; i < 3; i++) data_blk(2'b10);
            for (int k = 1; k <= 5; k++) begin // R6 all lengths
                skp_blk(k);
                data_blk(2'b10);
                data_blk(2'b01);
            end
            for (int i = 0; i < 20; i++) data_blk(2'b10); // R7 stall point
            data_blk(2'b11); data_blk(2'b00); data_blk(2'b11); // R8 broken run
            data_blk(2'b10);
            data_blk(2'b10);
            data_blk(2'b00); data_blk(2'b11); data_blk(2'b00);
            expect_out = 1'b0;
            data_blk(2'b11); // R8 fourth, dropped
            for (int i = 0; i < 96; i++) sq.push_back(1'b0);

            repeat (2) @(negedge clk);
            chk(!locked && !out_valid, "R1",
                $sformatf("reset lock=%0d valid=%0d exp=0/0", locked, out_valid));
            rst     = 1'b0;
            running = 1'b1;
            while (sq.size() > 0) begin
                logic [31:0] w;
                w = '0;
                for (int b = 0; b < 32; b++)
                    if (sq.size() > 0) w[b] = sq.pop_front();
                in_word = w;
                @(negedge clk);
            end
            in_word = '0;
            repeat (6) @(negedge clk);
            chk(ed.size() == 0, "R7",
                $sformatf("words left act=%0d exp=0", ed.size()));
            chk(!locked, "R8", $sformatf("locked act=%0d exp=0", locked));
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule